// File: doc/BRIEF.md
# Preempting Interrupt CPU Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending interrupt as a candidate, an ID and an 8-bit priority where a lower number means more urgent. The interface raises a request to the processor only when four things hold. The interface is enabled. The candidate is numerically below the programmed priority mask. The candidate wins preemption against the interrupt now running. The nesting stack still has room.

The processor takes an interrupt with an acknowledge read. The read returns the candidate's ID and pushes its ID and priority onto a last-in, first-out stack of active interrupts. The priority on top of that stack is the running priority. A later candidate preempts only if its priority group is strictly more urgent than the running group. The group is the priority with the low bits cleared, and the binary-point setting picks how many low bits are cleared. A completion write names an ID. When that ID is on top of the stack, the entry is popped. Acknowledges and completions are both echoed to the distributor as one-cycle strobes carrying the ID.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset irqReq is 0, runPrio is 0xFF, ackId is 1023 (all ones), eoiError is 0, and distAck and distEoi are 0.
- R2: While ifEnable is 0, irqReq is 0 whatever the candidate.
- R3: With the interface enabled, a valid candidate and an empty stack, irqReq is 1 exactly when candPrio < prioMask. With a mask of 0xF0, a priority of 0xEF is signalled and 0xF0 is not.
- R4: With a non-empty stack, a candidate that passes the mask is signalled only if (candPrio >> (binPoint+1)) < (runPrio >> (binPoint+1)). The low bits [binPoint:0] are ignored, so with binPoint = 7 nothing preempts.
- R5: An acknowledge read while irqReq is 1 makes ackId equal candId on the next cycle. It pulses distAck for one cycle with distAckId = candId, and runPrio becomes candPrio.
- R6: An acknowledge read while irqReq is 0 makes ackId 1023 on the next cycle, gives no distAck pulse, and leaves runPrio unchanged.
- R7: A completion write whose eoiId equals the ID on top of the stack pops it. distEoi pulses for one cycle with distEoiId = eoiId. runPrio returns to the entry below, or to 0xFF when the stack is empty. Completions therefore retire in reverse order of acknowledgement.
- R8: A completion write whose ID does not match the top entry, or that arrives with an empty stack, changes no stack state and gives no distEoi pulse. It sets eoiError, which stays 1 until reset.
- R9: The stack holds STACK_DEPTH (8) entries. While it is full, irqReq is 0.
- R10: A completion write in the same cycle as an acknowledge read is ignored. It gives no pop, no distEoi pulse and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifEnable | input | 1 | Interface enable |
| prioMask | input | 8 | Priority mask; candidates must be numerically below it |
| binPoint | input | 3 | Binary point; bits [binPoint:0] are ignored for preemption |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority (lower is more urgent) |
| ackRead | input | 1 | Acknowledge read strobe |
| eoiWrite | input | 1 | Completion write strobe |
| eoiId | input | 10 | ID named by the completion write |
| irqReq | output | 1 | Interrupt request to the processor |
| ackId | output | 10 | ID returned by the last acknowledge read |
| runPrio | output | 8 | Running priority (top of stack, 0xFF if empty) |
| distAck | output | 1 | One-cycle acknowledge notice to the distributor |
| distAckId | output | 10 | ID acknowledged |
| distEoi | output | 1 | One-cycle completion notice to the distributor |
| distEoiId | output | 10 | ID completed |
| eoiError | output | 1 | Sticky flag for a completion out of order |

## Verification
The bench builds the block with its defaults: 10-bit IDs, 8-bit priorities and an 8-entry stack. With these values a full sweep of all 256 candidate priorities can be run against three running priorities at every one of the 8 binary-point settings, so each group boundary of the preemption compare is reached. The shallow stack lets the bench fill it to the full state and unwind it in order. Along the way it checks the mask edge at 0xF0, completions out of order, and an acknowledge and a completion arriving together.

// File: rtl/irq_cpuif_pkg.sv
package irq_cpuif_pkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic push;     // acknowledge taken: push candidate
    logic ackMiss;  // acknowledge with nothing signalled
    logic pop;      // completion matched the top entry
    logic eoiBad;   // completion out of order or on empty stack
  } cpuStrobe_t;
endpackage

// File: rtl/irq_cpuif_ctrl.sv
module irq_cpuif_ctrl
  import irq_cpuif_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int ID_W   = 10,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifEnable,
  input  logic [PRIO_W-1:0] prioMask,
  input  logic [BP_W-1:0]   binPoint,
  input  logic              candValid,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              ackRead,
  input  logic              eoiWrite,
  input  logic [ID_W-1:0]   eoiId,
  input  logic [ID_W-1:0]   topId,
  input  logic [PRIO_W-1:0] topPrio,
  input  logic              stackEmpty,
  input  logic              stackFull,
  output logic              irqReq,
  output cpuStrobe_t        strobes
);
  localparam logic [PRIO_W-1:0] ALL_ONES = '1;

  logic [BP_W:0]     shiftAmt;
  logic [PRIO_W-1:0] grpMask;
  logic              beatsMask;
  logic              preempts;
  logic              eoiHit;
  logic              eoiLive;

  always_comb begin
    shiftAmt  = {1'b0, binPoint} + 1'b1;
    grpMask   = ALL_ONES << shiftAmt;
    beatsMask = candPrio < prioMask;
    preempts  = stackEmpty || ((candPrio & grpMask) < (topPrio & grpMask));
    irqReq    = ifEnable && candValid && beatsMask && preempts && !stackFull;

    eoiLive   = eoiWrite && !ackRead;
    eoiHit    = eoiLive && !stackEmpty && (eoiId == topId);

    strobes.push    = ackRead && irqReq;
    strobes.ackMiss = ackRead && !irqReq;
    strobes.pop     = eoiHit;
    strobes.eoiBad  = eoiLive && !eoiHit;
  end

  assert_no_req_when_off_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !ifEnable |-> !irqReq);

  assert_no_req_when_full_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    stackFull |-> !strobes.push);

  assert_eoi_yields_to_ack_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    ackRead |-> !(strobes.pop || strobes.eoiBad));
endmodule

// File: rtl/irq_cpuif_dp.sv
module irq_cpuif_dp
  import irq_cpuif_pkg::*;
#(
  parameter int PRIO_W      = 8,
  parameter int ID_W        = 10,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cpuStrobe_t        strobes,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  output logic [ID_W-1:0]   topId,
  output logic [PRIO_W-1:0] topPrio,
  output logic              stackEmpty,
  output logic              stackFull,
  output logic [ID_W-1:0]   ackId,
  output logic              distAck,
  output logic [ID_W-1:0]   distAckId,
  output logic              distEoi,
  output logic [ID_W-1:0]   distEoiId,
  output logic              eoiError
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [ID_W-1:0]   SPURIOUS = '1;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;
  localparam logic [CNT_W-1:0]  DEPTH_MAX = CNT_W'(STACK_DEPTH);

  logic [ID_W-1:0]   idStk [STACK_DEPTH];
  logic [PRIO_W-1:0] prStk [STACK_DEPTH];
  logic [CNT_W-1:0]  depth;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;

  always_comb begin
    stackEmpty = (depth == '0);
    stackFull  = (depth == DEPTH_MAX);
    topIdx     = IDX_W'(depth - 1'b1);
    pushIdx    = IDX_W'(depth);
    topId      = stackEmpty ? '0 : idStk[topIdx];
    topPrio    = stackEmpty ? IDLE_PRIO : prStk[topIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) begin
        idStk[i] <= '0;
        prStk[i] <= '0;
      end
    end else if (strobes.push) begin
      idStk[pushIdx] <= candId;
      prStk[pushIdx] <= candPrio;
      depth          <= depth + 1'b1;
    end else if (strobes.pop) begin
      depth <= depth - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackId     <= SPURIOUS;
      distAck   <= 1'b0;
      distAckId <= '0;
      distEoi   <= 1'b0;
      distEoiId <= '0;
      eoiError  <= 1'b0;
    end else begin
      distAck <= strobes.push;
      distEoi <= strobes.pop;
      if (strobes.push) begin
        ackId     <= candId;
        distAckId <= candId;
      end else if (strobes.ackMiss) begin
        ackId <= SPURIOUS;
      end
      if (strobes.pop) distEoiId <= topId;
      if (strobes.eoiBad) eoiError <= 1'b1;
    end
  end

  assert_ack_notifies_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.push |=> (distAck && distAckId == ackId && topPrio == $past(candPrio)));

  assert_miss_is_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ackMiss |=> (ackId == SPURIOUS && !distAck && $stable(depth)));

  assert_pop_notifies_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pop |=> (distEoi && depth == $past(depth) - 1'b1));

  assert_error_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    eoiError |=> eoiError);

  assert_no_overflow_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DEPTH_MAX);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpuif_pkg::*;
#(
  parameter int PRIO_W      = 8,
  parameter int ID_W        = 10,
  parameter int BP_W        = 3,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifEnable,
  input  logic [PRIO_W-1:0] prioMask,
  input  logic [BP_W-1:0]   binPoint,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              ackRead,
  input  logic              eoiWrite,
  input  logic [ID_W-1:0]   eoiId,
  output logic              irqReq,
  output logic [ID_W-1:0]   ackId,
  output logic [PRIO_W-1:0] runPrio,
  output logic              distAck,
  output logic [ID_W-1:0]   distAckId,
  output logic              distEoi,
  output logic [ID_W-1:0]   distEoiId,
  output logic              eoiError
);
  cpuStrobe_t        strobes;
  logic [ID_W-1:0]   topId;
  logic              stackEmpty;
  logic              stackFull;

  irq_cpuif_ctrl #(.PRIO_W(PRIO_W), .ID_W(ID_W), .BP_W(BP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ifEnable(ifEnable), .prioMask(prioMask),
    .binPoint(binPoint), .candValid(candValid), .candPrio(candPrio),
    .ackRead(ackRead), .eoiWrite(eoiWrite), .eoiId(eoiId), .topId(topId),
    .topPrio(runPrio), .stackEmpty(stackEmpty), .stackFull(stackFull),
    .irqReq(irqReq), .strobes(strobes)
  );

  irq_cpuif_dp #(.PRIO_W(PRIO_W), .ID_W(ID_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .candId(candId),
    .candPrio(candPrio), .topId(topId), .topPrio(runPrio),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .ackId(ackId),
    .distAck(distAck), .distAckId(distAckId), .distEoi(distEoi),
    .distEoiId(distEoiId), .eoiError(eoiError)
  );
endmodule

// File: tb/irq_cpu_if_tb.sv
`timescale 1ns/1ps
module irq_cpu_if_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ifEnable = 0;
  logic [7:0] prioMask = 8'hF0;
  logic [2:0] binPoint = 0;
  logic       candValid = 0;
  logic [9:0] candId = 0;
  logic [7:0] candPrio = 0;
  logic       ackRead = 0;
  logic       eoiWrite = 0;
  logic [9:0] eoiId = 0;
  logic       irqReq, distAck, distEoi, eoiError;
  logic [9:0] ackId, distAckId, distEoiId;
  logic [7:0] runPrio;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the active stack
  int mPrio [8];
  int mId [8];
  int mDepth = 0;

  always #5 clk = ~clk;

  irq_cpu_if u_dut (
    .clk(clk), .rst_n(rst_n), .ifEnable(ifEnable), .prioMask(prioMask),
    .binPoint(binPoint), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .ackRead(ackRead), .eoiWrite(eoiWrite), .eoiId(eoiId),
    .irqReq(irqReq), .ackId(ackId), .runPrio(runPrio), .distAck(distAck),
    .distAckId(distAckId), .distEoi(distEoi), .distEoiId(distEoiId),
    .eoiError(eoiError)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRun();
    return (mDepth == 0) ? 255 : mPrio[mDepth-1];
  endfunction

  function automatic int expReq(int p);
    int top;
    bit pre;
    top = expRun();
    pre = (mDepth == 0) || ((p >> (int'(binPoint) + 1)) < (top >> (int'(binPoint) + 1)));
    return (ifEnable && candValid && p < int'(prioMask) && mDepth < 8 && pre) ? 1 : 0;
  endfunction

  task automatic offer(int id, int p);
    @(negedge clk);
    candValid = 1; candId = 10'(id); candPrio = 8'(p);
    #1;
  endtask

  // acknowledge the current candidate and check the outcome
  task automatic doAck(string req);
    int hit;
    int id;
    int p;
    hit = expReq(int'(candPrio)); id = int'(candId); p = int'(candPrio);
    ackRead = 1;
    @(negedge clk);
    ackRead = 0;
    if (hit == 1) begin
      mPrio[mDepth] = p; mId[mDepth] = id; mDepth++;
      check(req, int'(ackId), id);
      check(req, int'(distAck), 1);
      check(req, int'(distAckId), id);
    end else begin
      check(req, int'(ackId), 1023);
      check(req, int'(distAck), 0);
    end
    check(req, int'(runPrio), expRun());
    #1;
  endtask

  task automatic doEoi(string req, int id);
    bit hit;
    bit errBefore;
    hit = (mDepth > 0) && (mId[mDepth-1] == id);
    errBefore = eoiError;
    @(negedge clk);
    eoiWrite = 1; eoiId = 10'(id);
    @(negedge clk);
    eoiWrite = 0;
    if (hit) begin
      mDepth--;
      check(req, int'(distEoi), 1);
      check(req, int'(distEoiId), id);
      check(req, int'(eoiError), int'(errBefore));
    end else begin
      check(req, int'(distEoi), 0);
      check(req, int'(eoiError), 1);
    end
    check(req, int'(runPrio), expRun());
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(irqReq), 0);
    check("R1", int'(runPrio), 255);
    check("R1", int'(ackId), 1023);
    check("R1", int'(eoiError), 0);
    check("R1", int'(distAck) + int'(distEoi), 0);
    rst_n = 1;

    // R2 disabled: sweep all priorities
    for (int p = 0; p < 256; p++) begin
      offer(5, p);
      check("R2", int'(irqReq), 0);
    end
    ifEnable = 1;

    // R3 mask boundary and sweep with empty stack
    for (int m = 0; m < 256; m += 16) begin
      prioMask = 8'(m);
      for (int p = 0; p < 256; p++) begin
        offer(5, p);
        check("R3", int'(irqReq), expReq(p));
      end
    end
    prioMask = 8'hF0;
    offer(7, 8'hEF); check("R3", int'(irqReq), 1);
    offer(7, 8'hF0); check("R3", int'(irqReq), 0);

    // R6 acknowledge with nothing signalled
    candValid = 0; #1;
    doAck("R6");

    // R4/R5/R7 preemption sweep over binary point and running priority
    for (int bp = 0; bp < 8; bp++) begin
      binPoint = 3'(bp);
      for (int k = 0; k < 3; k++) begin
        int tp;
        tp = (k == 0) ? 8'h10 : (k == 1) ? 8'h47 : 8'h80;
        offer(100 + k, tp);
        doAck("R5");
        for (int p = 0; p < 256; p++) begin
          offer(200, p);
          check("R4", int'(irqReq), expReq(p));
        end
        doEoi("R7", 100 + k);
      end
    end

    // R7 nested LIFO; R9 full stack
    binPoint = 0;
    for (int n = 0; n < 8; n++) begin
      offer(300 + n, 8'hE0 - 8'(n * 16));
      doAck("R7");
    end
    offer(400, 0);
    check("R9", int'(irqReq), 0);
    doAck("R9");
    check("R9", int'(runPrio), 8'h70);

    // R8 out-of-order completion: ignored, sticky error
    doEoi("R8", 300);
    check("R8", int'(runPrio), 8'h70);
    for (int n = 7; n >= 0; n--) doEoi("R7", 300 + n);
    check("R7", int'(runPrio), 255);
    doEoi("R8", 300);
    check("R8", int'(eoiError), 1);

    // R10 ack and completion in the same cycle
    offer(500, 8'h20);
    @(negedge clk);
    ackRead = 1; eoiWrite = 1; eoiId = 10'd500;
    @(negedge clk);
    ackRead = 0; eoiWrite = 0;
    mPrio[0] = 8'h20; mId[0] = 500; mDepth = 1;
    check("R10", int'(distAck), 1);
    check("R10", int'(distEoi), 0);
    check("R10", int'(runPrio), 8'h20);
    doEoi("R10", 500);

    // reset clears the sticky error (R1)
    @(negedge clk); rst_n = 0; #1;
    check("R1", int'(eoiError), 0);
    mDepth = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule